// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is the serial core of a master-only SPI controller. It pulls bytes from the read side of a transmit FIFO and shifts them out on the data-out line. At the same time it assembles the bits seen on the data-in line into bytes and pushes them into a receive FIFO. Static configuration inputs set the clock polarity, the clock phase, the bit order, which of four select lines is used, and whether that line is driven automatically or held at a level chosen by software.

A burst starts with a one-cycle exchange request, and its byte count is presented on `burst_len` in that cycle. The busy output reads back high for the whole burst and drops by itself at the end. Timing comes from `half_tick`, a one-cycle strobe from an external divider that marks each half bit period. When the burst finishes, a one-cycle completion pulse is raised. If the transmit FIFO is empty when a byte is due, the engine holds the serial clock and waits. Dropping the enable, or raising the soft reset, abandons any burst and returns the engine to idle.

Top module: `spi_xfer_engine`

## Requirements
- R1: Only the select line indexed by `cfg_cs_sel` (0 to 3) is ever driven low. Every other line of `spi_cs_n` stays high, and after reset all four lines are high.
- R2: With `cfg_cs_manual`=1 and the engine enabled, the selected line equals `cfg_cs_level` (1 = high) at all times, bursts included. With the engine disabled, all lines are high whatever the manual setting.
- R3: Between bursts `spi_sclk` rests at `cfg_cpol`. Each byte produces exactly 16 clock edges.
- R4: With `cfg_cpha`=0, both sides sample on the first (leading) edge of each bit and change data on the trailing edge. With `cfg_cpha`=1, data changes on the leading edge and is sampled on the trailing edge. Bytes therefore pass intact in both directions in all four clock modes.
- R5: `cfg_lsb_first`=1 shifts bit 0 of each byte first, and 0 shifts bit 7 first. This applies to both data lines.
- R6: A `xch_set` pulse while enabled and idle, with a nonzero `burst_len`, starts a burst of exactly `burst_len` bytes. `xch_busy` is 1 from the next cycle until the burst ends. A pulse while busy, or with `burst_len`=0, is ignored. One `rx_push` is made per byte.
- R7: `xfer_done` is a single-cycle pulse, issued once per completed burst, one half period after the last clock edge.
- R8: Clearing `cfg_enable` or raising `cfg_soft_rst` returns the engine to idle in the next cycle. It then shows no busy, no completion pulse, select lines high and the clock at its idle level. A start request is ignored while the engine is disabled.
- R9: While the transmit FIFO is empty and a byte is due, no clock edge is produced, the burst stays busy and the select line stays asserted. Shifting resumes once data arrives.
- R10: In automatic mode the selected line goes low in the cycle after the accepted `xch_set`. It returns high in the same cycle in which `xfer_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Engine enable |
| cfg_soft_rst | input | 1 | Return to idle, aborting any burst |
| cfg_cpol | input | 1 | Idle clock level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: bit 0 first, 0: bit 7 first |
| cfg_cs_sel | input | 2 | Index of the select line in use |
| cfg_cs_manual | input | 1 | Select line follows `cfg_cs_level` |
| cfg_cs_level | input | 1 | Manual select level, 1 = high |
| burst_len | input | 8 | Byte count taken at start |
| xch_set | input | 1 | Start request pulse |
| xch_busy | output | 1 | Burst in progress |
| half_tick | input | 1 | Half bit period strobe |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 8 | Transmit FIFO head byte |
| tx_pop | output | 1 | Consume the transmit FIFO head byte |
| rx_data | output | 8 | Received byte, valid with `rx_push` |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Select lines, active low |
| xfer_done | output | 1 | Burst complete pulse |

## Verification
The assertions take it that `tx_empty` is honest, so a byte is never popped from an empty FIFO. They also take it that the mode, bit-order and select fields stay fixed while a burst runs, and that `half_tick` is never high two cycles in a row, so each half period lasts at least two clocks. The stimulus changes the configuration only between bursts and makes `half_tick` a one-in-three strobe. Its FIFO model reports empty whenever its preloaded list is used up or a stall is forced. This keeps a start request made during a burst from ever finding unexpected data.

// File: rtl/spi_xfer_pkg.sv
// Shared types for the SPI transfer engine.
// Assumes nothing beyond IEEE 1800-2017.
package spi_xfer_pkg;

    // Burst sequencer states
    typedef enum logic [1:0] {
        ST_IDLE,   // no burst
        ST_FETCH,  // waiting for a transmit byte (half period before edges)
        ST_SHIFT,  // producing clock edges for one byte
        ST_TRAIL   // last half period before the select line is released
    } xfer_state_t;

endpackage

// File: rtl/spi_burst_ctrl.sv
// Burst sequencer: counts bytes and clock edges, stalls on an empty
// transmit FIFO and raises the completion pulse.
// Assumes half_tick is a single-cycle strobe per half bit period.
module spi_burst_ctrl
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int EDGE_W = $clog2(2 * DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              soft_rst,
    input  logic              xch_set,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic              tick,
    input  logic              tx_empty,
    output xfer_state_t       state,
    output logic              tx_pop,
    output logic              edge_tick,
    output logic [EDGE_W-1:0] edge_idx,
    output logic              byte_end,
    output logic              sclk_phase,
    output logic              busy,
    output logic              done
);

    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);

    logic             halt;
    logic [CNT_W-1:0] remaining;

    // Decode the per-cycle strobes from state and the half-period tick
    always_comb begin
        halt       = !enable || soft_rst;
        tx_pop     = (state == ST_FETCH) && tick && !tx_empty && !halt;
        edge_tick  = (state == ST_SHIFT) && tick && !halt;
        byte_end   = edge_tick && (edge_idx == LAST_EDGE);
        sclk_phase = edge_idx[0];
        busy       = (state != ST_IDLE);
    end

    // Sequence a burst: start, fetch, shift, trail, with abort on halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            remaining <= '0;
            edge_idx  <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (halt) begin
                state     <= ST_IDLE;
                remaining <= '0;
                edge_idx  <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (xch_set && (burst_len != '0)) begin
                            remaining <= burst_len;
                            state     <= ST_FETCH;
                        end
                    end
                    ST_FETCH: begin
                        if (tx_pop) state <= ST_SHIFT;
                    end
                    ST_SHIFT: begin
                        if (byte_end) begin
                            edge_idx  <= '0;
                            remaining <= remaining - 1'b1;
                            state     <= (remaining == CNT_W'(1)) ? ST_TRAIL : ST_FETCH;
                        end else if (edge_tick) begin
                            edge_idx <= edge_idx + 1'b1;
                        end
                    end
                    ST_TRAIL: begin
                        if (tick) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // An empty FIFO freezes the clock phase and keeps the burst waiting
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && tx_empty && enable && !soft_rst)
        |=> (state == ST_FETCH && $stable(edge_idx)));

    // Active fetch or shift always has bytes left to move
    p_count_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH || state == ST_SHIFT) |-> (remaining != '0));

    // The completion pulse coincides with idle
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == ST_IDLE));

    // Idle clock always rests at phase zero
    p_idle_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (edge_idx == '0));

    // A halt request lands the sequencer in idle on the next cycle
    p_halt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || soft_rst) |=> (state == ST_IDLE && !done));

endmodule

// File: rtl/spi_bit_shifter.sv
// Data path: transmit and receive shift registers with mode-dependent
// change/sample edges and selectable bit order.
// Assumes cpha and lsb_first are stable for the duration of a burst.
module spi_bit_shifter #(
    parameter int DATA_W = 8,
    parameter int EDGE_W = $clog2(2 * DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              edge_tick,
    input  logic [EDGE_W-1:0] edge_idx,
    input  logic              byte_end,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_push
);

    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);

    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [DATA_W-1:0] rx_shifted;
    logic [DATA_W-1:0] rx_nxt;
    logic              leading;
    logic              drive_now;
    logic              sample_now;

    // Choose which edges move data out and which capture data in
    always_comb begin
        leading    = !edge_idx[0];
        drive_now  = edge_tick && (cpha ? (leading && (edge_idx != '0))
                                        : (!leading && (edge_idx != LAST_EDGE)));
        sample_now = edge_tick && (cpha ? !leading : leading);
        rx_shifted = lsb_first ? {miso, rx_sr[DATA_W-1:1]}
                               : {rx_sr[DATA_W-2:0], miso};
        rx_nxt     = sample_now ? rx_shifted : rx_sr;
        mosi       = lsb_first ? tx_sr[0] : tx_sr[DATA_W-1];
    end

    // Shift registers and the received-byte handoff
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            rx_data <= '0;
            rx_push <= 1'b0;
        end else begin
            if (load) begin
                tx_sr <= tx_data;
            end else if (drive_now) begin
                tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
            end
            rx_sr   <= rx_nxt;
            rx_push <= byte_end;
            if (byte_end) rx_data <= rx_nxt;
        end
    end

    // Bytes take many cycles, so pushes never come back to back
    p_push_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);

    // Outgoing bit holds across every sampling edge
    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_now && !load) |=> $stable(mosi));

endmodule

// File: rtl/spi_cs_decode.sv
// Select-line decoder: one line per index, automatic or software level.
// Assumes CS_N does not exceed the range of the select field.
module spi_cs_decode #(
    parameter int CS_N  = 4,
    parameter int SEL_W = $clog2(CS_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             busy,
    input  logic             manual,
    input  logic             level,
    input  logic [SEL_W-1:0] sel,
    output logic [CS_N-1:0]  cs_n
);

    logic line_val;

    // Level the selected line takes in the current mode
    always_comb begin
        line_val = manual ? level : !busy;
    end

    // Drive each line high unless it is the enabled, selected one
    for (genvar gi = 0; gi < CS_N; gi++) begin : g_line
        assign cs_n[gi] = (enable && (sel == SEL_W'(gi))) ? line_val : 1'b1;
    end

    // Never more than one select line low
    p_one_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    // Disabled engine releases every line
    p_disabled_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (cs_n == '1));

endmodule

// File: rtl/spi_xfer_engine.sv
// Top of the SPI master transfer engine: sequencer, shifter and
// select decoder, plus the idle-level clock output.
// Assumes configuration is held steady while xch_busy is high and the
// FIFOs sit outside this block.
module spi_xfer_engine
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int CS_N   = 4,
    parameter int SEL_W  = $clog2(CS_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_soft_rst,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_lsb_first,
    input  logic [SEL_W-1:0]  cfg_cs_sel,
    input  logic              cfg_cs_manual,
    input  logic              cfg_cs_level,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic              xch_set,
    output logic              xch_busy,
    input  logic              half_tick,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_push,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [CS_N-1:0]   spi_cs_n,
    output logic              xfer_done
);

    localparam int EDGE_W = $clog2(2 * DATA_W);

    xfer_state_t       state;
    logic              edge_tick;
    logic [EDGE_W-1:0] edge_idx;
    logic              byte_end;
    logic              sclk_phase;

    spi_burst_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .EDGE_W(EDGE_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_enable),
        .soft_rst   (cfg_soft_rst),
        .xch_set    (xch_set),
        .burst_len  (burst_len),
        .tick       (half_tick),
        .tx_empty   (tx_empty),
        .state      (state),
        .tx_pop     (tx_pop),
        .edge_tick  (edge_tick),
        .edge_idx   (edge_idx),
        .byte_end   (byte_end),
        .sclk_phase (sclk_phase),
        .busy       (xch_busy),
        .done       (xfer_done)
    );

    spi_bit_shifter #(.DATA_W(DATA_W), .EDGE_W(EDGE_W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpha      (cfg_cpha),
        .lsb_first (cfg_lsb_first),
        .load      (tx_pop),
        .tx_data   (tx_data),
        .edge_tick (edge_tick),
        .edge_idx  (edge_idx),
        .byte_end  (byte_end),
        .miso      (spi_miso),
        .mosi      (spi_mosi),
        .rx_data   (rx_data),
        .rx_push   (rx_push)
    );

    spi_cs_decode #(.CS_N(CS_N), .SEL_W(SEL_W)) i_cs (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (cfg_enable),
        .busy   (xch_busy),
        .manual (cfg_cs_manual),
        .level  (cfg_cs_level),
        .sel    (cfg_cs_sel),
        .cs_n   (spi_cs_n)
    );

    // Serial clock: phase counter bit folded with the idle polarity
    always_comb begin
        spi_sclk = cfg_cpol ^ sclk_phase;
    end

    // Clock rests at the polarity level whenever no burst runs
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !xch_busy |-> (spi_sclk == cfg_cpol));

    // Automatic select releases together with the completion pulse
    p_cs_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (spi_cs_n == '1 || cfg_cs_manual));

endmodule

// File: tb/test_spi_xfer_engine.sv
// Self-checking bench: SPI slave model, FIFO model and sweeps over
// all clock modes, bit orders and select lines.
module test_spi_xfer_engine;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1, soft_rst = 1'b0;
    logic       cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
    logic [1:0] cs_sel = 2'd0;
    logic       cs_manual = 1'b0, cs_level = 1'b1;
    logic [7:0] burst_len = 8'd0;
    logic       xch_set = 1'b0;
    logic       busy, tick = 1'b0, tx_empty, tx_pop, rx_push, sclk, mosi, done;
    logic       miso = 1'b0;
    logic [7:0] tx_data, rx_data;
    logic [3:0] cs_n;

    logic [7:0] m_tx [0:7];
    logic [7:0] s_tx [0:7];
    logic [7:0] s_got [0:7];
    logic [7:0] m_got [0:7];
    int  tx_rd = 0, tx_avail = 0, tick_cnt = 0;
    int  n_edges = 0, n_done = 0, n_mrx = 0, n_slv = 0;
    int  sbit = 0, sbyte = 0;
    logic [7:0] s_sr = 8'd0;
    bit  force_empty = 0, pop_pend = 0, cs_bad = 0, done_cs_bad = 0, first_taken = 0;
    logic first_bit = 1'b0;
    logic [3:0] cs_low_seen = 4'd0;
    logic sclk_prev = 1'b0;
    int  errors = 0, checks = 0;

    assign tx_empty = force_empty || (tx_rd >= tx_avail);
    assign tx_data  = m_tx[tx_rd[2:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_xfer_engine i_spi_xfer_engine (
        .clk(clk), .rst_n(rst_n), .cfg_enable(enable), .cfg_soft_rst(soft_rst),
        .cfg_cpol(cpol), .cfg_cpha(cpha), .cfg_lsb_first(lsb), .cfg_cs_sel(cs_sel),
        .cfg_cs_manual(cs_manual), .cfg_cs_level(cs_level), .burst_len(burst_len),
        .xch_set(xch_set), .xch_busy(busy), .half_tick(tick), .tx_empty(tx_empty),
        .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push),
        .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n),
        .xfer_done(done)
    );

    function automatic logic slave_bit();
        logic [7:0] b = s_tx[sbyte % 8];
        return lsb ? b[sbit] : b[7 - sbit];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: tick generation, FIFO pointer, slave model, event counters
    initial begin
        forever begin
            @(negedge clk);
            if (pop_pend) tx_rd++;
            tick_cnt = (tick_cnt + 1) % 3;
            tick = (tick_cnt == 0);
            #1;
            pop_pend = tx_pop;
            if (sclk !== sclk_prev) begin
                logic leading;
                n_edges++;
                leading = (sclk != cpol);
                if (cpha ? !leading : leading) begin
                    s_sr = lsb ? {mosi, s_sr[7:1]} : {s_sr[6:0], mosi};
                    if (!first_taken) begin first_bit = mosi; first_taken = 1; end
                end
                if (cpha && leading) miso = slave_bit();
                if (!leading) begin
                    sbit++;
                    if (sbit == 8) begin
                        s_got[sbyte % 8] = s_sr;
                        n_slv++; sbyte++; sbit = 0;
                    end
                    if (!cpha) miso = slave_bit();
                end
            end
            sclk_prev = sclk;
            if (rx_push) begin m_got[n_mrx % 8] = rx_data; n_mrx++; end
            if (done) begin
                n_done++;
                if (!cs_manual && cs_n != 4'hF) done_cs_bad = 1;
            end
            if (busy && !cs_manual && cs_n != ~(4'b0001 << cs_sel)) cs_bad = 1;
            cs_low_seen = cs_low_seen | ~cs_n;
        end
    end

    task automatic prep(input int len, input int seed, input logic pol,
                        input logic pha, input logic lf, input logic [1:0] sel);
        @(negedge clk);
        cpol = pol; cpha = pha; lsb = lf; cs_sel = sel;
        for (int k = 0; k < 8; k++) begin
            m_tx[k] = 8'((k + 1) * 8'h3B) ^ 8'(seed * 8'h11);
            s_tx[k] = 8'hA5 ^ 8'(k * 8'h27) ^ 8'(seed);
        end
        m_tx[0] = 8'h80 | (8'(seed * 8'h0C) & 8'h7E);
        tx_rd = 0; tx_avail = len;
        repeat (2) @(negedge clk);
        n_edges = 0; n_done = 0; n_mrx = 0; n_slv = 0;
        sbit = 0; sbyte = 0; s_sr = 8'd0; first_taken = 0;
        cs_bad = 0; done_cs_bad = 0; cs_low_seen = 4'd0;
        miso = slave_bit();
    endtask

    task automatic kick(input int len);
        @(negedge clk);
        burst_len = 8'(len); xch_set = 1'b1;
        @(negedge clk);
        xch_set = 1'b0;
        #2;
    endtask

    task automatic wait_done();
        bit seen = 0;
        for (int w = 0; w < 3000 && !seen; w++) begin
            @(negedge clk); #2;
            if (n_done != 0) seen = 1;
        end
        check(seen, "R7 completion pulse seen", int'(seen), 1);
        repeat (4) @(negedge clk);
        #2;
    endtask

    task automatic verify(input int len);
        logic exp_first;
        check(n_done == 1, "R7 one completion pulse", n_done, 1);
        check(n_edges == 16 * len, "R3 edge count", n_edges, 16 * len);
        check(sclk == cpol, "R3 idle clock level", int'(sclk), int'(cpol));
        check(n_mrx == len, "R6 receive pushes", n_mrx, len);
        check(busy == 1'b0, "R6 busy cleared", int'(busy), 0);
        for (int k = 0; k < len; k++) begin
            check(s_got[k] == m_tx[k], "R4 byte seen by slave", s_got[k], m_tx[k]);
            check(m_got[k] == s_tx[k], "R4 byte received", m_got[k], s_tx[k]);
        end
        exp_first = lsb ? m_tx[0][0] : m_tx[0][7];
        check(first_bit == exp_first, "R5 first bit on line", int'(first_bit), int'(exp_first));
        if (!cs_manual) begin
            check(!cs_bad, "R1 only selected line low", int'(cs_bad), 0);
            check(!done_cs_bad, "R10 release with done", int'(done_cs_bad), 0);
            check(cs_low_seen == (4'b0001 << cs_sel), "R1 lines used",
                  cs_low_seen, 4'b0001 << cs_sel);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // Reset state
        check(busy == 1'b0, "R6 reset busy", int'(busy), 0);
        check(cs_n == 4'hF, "R1 reset lines", cs_n, 4'hF);
        check(sclk == 1'b0, "R3 reset clock", int'(sclk), 0);
        check(done == 1'b0 && rx_push == 1'b0, "R7 reset pulses", int'(done), 0);

        // Sweep all modes, bit orders and select lines
        for (int i = 0; i < 32; i++) begin
            int len;
            len = 1 + (i % 3);
            prep(len, i, i[0], i[1], i[2], 2'(i >> 3));
            kick(len);
            check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
            check(cs_n == ~(4'b0001 << cs_sel), "R10 line asserted after start",
                  cs_n, ~(4'b0001 << cs_sel));
            wait_done();
            verify(len);
        end

        // Zero length is ignored
        prep(2, 40, 1'b0, 1'b0, 1'b0, 2'd1);
        kick(0);
        repeat (20) @(negedge clk);
        #2;
        check(busy == 1'b0 && n_done == 0, "R6 zero length ignored", int'(busy), 0);
        check(n_edges == 0, "R6 zero length no clock", n_edges, 0);

        // Start request while busy is ignored
        prep(2, 41, 1'b1, 1'b1, 1'b0, 2'd2);
        kick(2);
        repeat (20) @(negedge clk);
        burst_len = 8'd5; xch_set = 1'b1;
        @(negedge clk);
        xch_set = 1'b0;
        wait_done();
        verify(2);

        // Stall on empty transmit FIFO
        prep(2, 42, 1'b0, 1'b1, 1'b1, 2'd3);
        force_empty = 1;
        kick(2);
        repeat (30) @(negedge clk);
        #2;
        check(n_edges == 0, "R9 no edges while empty", n_edges, 0);
        check(busy == 1'b1, "R9 busy while stalled", int'(busy), 1);
        check(cs_n == 4'b0111, "R9 line held while stalled", cs_n, 4'b0111);
        @(negedge clk);
        force_empty = 0;
        wait_done();
        verify(2);

        // Soft reset aborts a burst
        prep(3, 43, 1'b1, 1'b0, 1'b0, 2'd0);
        kick(3);
        repeat (40) @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        #2;
        check(busy == 1'b0, "R8 soft reset idles", int'(busy), 0);
        check(cs_n == 4'hF, "R8 lines released", cs_n, 4'hF);
        check(sclk == cpol, "R8 clock idle", int'(sclk), int'(cpol));
        repeat (100) @(negedge clk);
        #2;
        check(n_done == 0, "R8 no completion after abort", n_done, 0);

        // Disabled engine ignores start requests
        prep(2, 44, 1'b0, 1'b0, 1'b0, 2'd0);
        enable = 1'b0;
        kick(2);
        repeat (10) @(negedge clk);
        #2;
        check(busy == 1'b0 && n_edges == 0, "R8 start ignored while disabled", int'(busy), 0);
        @(negedge clk);
        enable = 1'b1;

        // Software-owned select line
        prep(2, 45, 1'b0, 1'b0, 1'b1, 2'd2);
        cs_manual = 1'b1; cs_level = 1'b0;
        #2;
        check(cs_n == 4'b1011, "R2 manual low", cs_n, 4'b1011);
        @(negedge clk);
        cs_level = 1'b1;
        #2;
        check(cs_n == 4'hF, "R2 manual high", cs_n, 4'hF);
        @(negedge clk);
        cs_level = 1'b0; enable = 1'b0;
        #2;
        check(cs_n == 4'hF, "R2 disabled overrides manual", cs_n, 4'hF);
        @(negedge clk);
        enable = 1'b1; cs_level = 1'b1;
        prep(2, 46, 1'b0, 1'b0, 1'b1, 2'd2);
        kick(2);
        wait_done();
        verify(2);
        check(cs_low_seen == 4'd0, "R2 manual high held through burst", cs_low_seen, 0);
        @(negedge clk);
        cs_level = 1'b0;
        prep(1, 47, 1'b1, 1'b0, 1'b0, 2'd2);
        kick(1);
        wait_done();
        verify(1);
        check(cs_low_seen == 4'b0100, "R2 manual low held through burst", cs_low_seen, 4'b0100);
        check(cs_n == 4'b1011, "R2 manual low after burst", cs_n, 4'b1011);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule